// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable model of a single-clock, flow-through burst static RAM built from byte-wide lanes (four lanes of eight bits by default). Every control, address and data input is captured on the rising clock edge. An access begins when one of two start strobes is sampled low: the controller strobe or the processor strobe. The two strobes follow different priority and qualification rules. After the first word, a two-bit sequencer steps through the remaining three words of an aligned group of four. It steps only on cycles where the advance input is low. It follows either a linear or an interleaved order, chosen by a strap input that is captured when the burst starts.

Writes may update any subset of the byte lanes, or all lanes through a global write input. The read path has no output register. The word at the captured address appears during the same cycle that follows the capturing edge. It is presented only while the asynchronous output enable is low. A snooze input forces the device idle. Three chip enables allow depth expansion. The depth is a parameter: the default is kept small, and a 64K-word part uses an address width of 16.

Top module: `fsb_sram`

## Requirements
- R1: A start is accepted only when the primary enable `ce_n` is 0, `ce2` is 1 and `ce2_n` is 0. A controller start with any other enable combination ends any burst, writes nothing, and leaves `q_drive` at 0 in the following cycle.
- R2: When `adsc_n` is sampled 0, a new access starts at `addr` whatever the value of `adsp_n`, provided the enables select the device. On that edge the data is written under the lane controls of R8/R9.
- R3: When `adsp_n` is 0, `adsc_n` is 1 and `ce_n` is 0, a read access starts at `addr`. Global and byte write inputs are ignored on that edge.
- R4: A processor strobe sampled while `ce_n` is 1 is ignored: a burst in progress continues, and it steps if `adv_n` is 0.
- R5: During a burst, the word address changes on a cycle with no start only if `adv_n` is sampled 0. With `adv_n` at 1 the address holds.
- R6: With `mode` = 1 captured at the start, the two low address bits for burst count k (0 to 3) are start XOR k.
- R7: With `mode` = 0 captured at the start, the two low address bits are (start + k) mod 4. For both orders the upper address bits never change inside a burst.
- R8: With `gw_n` = 1 and `bwe_n` = 0, lane i (data bits 8i+7 down to 8i) is written only if `bw_n[i]` is 0. With `bwe_n` = 1 no lane is written.
- R9: With `gw_n` = 0 all four lanes are written, whatever `bwe_n` and `bw_n` are.
- R10: During the cycle that follows an edge that did not write, `q_data` shows the word at the burst address captured on that edge, and `q_drive` is 1, provided `oe_n` is 0. In every other case `q_drive` is 0 and `q_data` is 0.
- R11: While `zz` is sampled 1, the device is idle and nothing is written. After `zz` returns to 0, only a new start produces an access.
- R12: After reset, the device is idle and `q_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address captured on a start |
| din | input | LANES*LANE_W | Write data |
| ce_n | input | 1 | Primary chip enable, active low; also qualifies the processor strobe |
| ce2 | input | 1 | Expansion enable, active high |
| ce2_n | input | 1 | Expansion enable, active low |
| adsp_n | input | 1 | Processor start strobe, active low |
| adsc_n | input | 1 | Controller start strobe, active low, highest priority |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte write qualifier, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| mode | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| zz | input | 1 | Snooze, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| q_data | output | LANES*LANE_W | Read data, zero when not driven |
| q_drive | output | 1 | High while read data is driven |

## Verification
A fault in the burst sequencer, or a start that is accepted wrongly, puts a wrong word on `q_data` in the very next read cycle. A write that lands wrongly stays hidden until that address is read again. For this reason every directed case ends with a read-back of the words it could have disturbed, and a long random phase reads constantly. A fault in the read/write status appears at once as a `q_drive` mismatch in the cycle after the edge. The bench compares against its model on every clock.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

   // Outcome of the decode of one sampled clock edge.
   typedef enum logic [1:0] {
      CYC_IDLE       = 2'd0,
      CYC_CTRL_START = 2'd1,
      CYC_PROC_START = 2'd2,
      CYC_CONT       = 2'd3
   } fsb_cyc_e;

   // Low two address bits for a burst count; md=1 interleaved, md=0 linear.
   function automatic logic [1:0] fsb_low_bits(input logic md,
                                                input logic [1:0] start,
                                                input logic [1:0] count);
      return md ? (start ^ count) : (start + count);
   endfunction

endpackage

// File: rtl/fsb_decode.sv
module fsb_decode #(
   parameter int LANES = 4
) (
   input  logic                  ce_n,
   input  logic                  ce2,
   input  logic                  ce2_n,
   input  logic                  adsp_n,
   input  logic                  adsc_n,
   input  logic                  gw_n,
   input  logic                  bwe_n,
   input  logic [LANES-1:0]      bw_n,
   input  logic                  zz,
   input  logic                  act_q,
   output fsb_pkg::fsb_cyc_e     cyc,
   output logic [LANES-1:0]      lane_we
);
   import fsb_pkg::*;

   logic             selected;
   logic [LANES-1:0] wr_mask;

   assign selected = ~ce_n & ce2 & ~ce2_n;

   always_comb begin
      if (zz)
         cyc = CYC_IDLE;
      else if (!adsc_n)
         cyc = selected ? CYC_CTRL_START : CYC_IDLE;
      else if (!adsp_n && !ce_n)
         cyc = selected ? CYC_PROC_START : CYC_IDLE;
      else
         cyc = act_q ? CYC_CONT : CYC_IDLE;
   end

   always_comb begin
      if (!gw_n)
         wr_mask = {LANES{1'b1}};
      else if (!bwe_n)
         wr_mask = ~bw_n;
      else
         wr_mask = '0;
   end

   // Processor starts are forced reads; idle edges write nothing.
   assign lane_we = (cyc == CYC_CTRL_START || cyc == CYC_CONT) ? wr_mask : '0;

endmodule

// File: rtl/fsb_burst.sv
module fsb_burst #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              mode_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_nxt,
   output logic [ADDR_W-1:0] addr_q
);
   import fsb_pkg::*;

   localparam int UP_W = ADDR_W - 2;

   logic [UP_W-1:0] up_q, up_d;
   logic [1:0]      st_q, st_d, cnt_q, cnt_d;
   logic            md_q, md_d;

   always_comb begin
      up_d  = up_q;
      st_d  = st_q;
      cnt_d = cnt_q;
      md_d  = md_q;
      if (load) begin
         up_d  = addr_in[ADDR_W-1:2];
         st_d  = addr_in[1:0];
         cnt_d = 2'd0;
         md_d  = mode_in;
      end else if (step) begin
         cnt_d = cnt_q + 2'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q  <= '0;
         st_q  <= 2'd0;
         cnt_q <= 2'd0;
         md_q  <= 1'b0;
      end else begin
         up_q  <= up_d;
         st_q  <= st_d;
         cnt_q <= cnt_d;
         md_q  <= md_d;
      end
   end

   assign addr_nxt = {up_d, fsb_low_bits(md_d, st_d, cnt_d)};
   assign addr_q   = {up_q, fsb_low_bits(md_q, st_q, cnt_q)};

endmodule

// File: rtl/fsb_array.sv
module fsb_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                      clk,
   input  logic [LANES-1:0]          we,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic [ADDR_W-1:0]         raddr,
   output logic [LANES*LANE_W-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we[g])
            store[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = store[raddr];
   end

endmodule

// File: rtl/fsb_sram.sv
module fsb_sram #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES*LANE_W-1:0]   din,
   input  logic                      ce_n,
   input  logic                      ce2,
   input  logic                      ce2_n,
   input  logic                      adsp_n,
   input  logic                      adsc_n,
   input  logic                      adv_n,
   input  logic                      gw_n,
   input  logic                      bwe_n,
   input  logic [LANES-1:0]          bw_n,
   input  logic                      mode,
   input  logic                      zz,
   input  logic                      oe_n,
   output logic [LANES*LANE_W-1:0]   q_data,
   output logic                      q_drive
);
   import fsb_pkg::*;

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 3 || ADDR_W > 20) begin : g_bad_addr_w
      $error("fsb_sram: ADDR_W must lie in 3..20");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("fsb_sram: LANES and LANE_W must be positive");
   end

   fsb_cyc_e          cyc;
   logic [LANES-1:0]  lane_we;
   logic              act_q, rd_q;
   logic              start, step;
   logic [ADDR_W-1:0] addr_nxt, addr_q;
   logic [DATA_W-1:0] rdata;

   fsb_decode #(.LANES(LANES)) u_decode (
      .ce_n    (ce_n),
      .ce2     (ce2),
      .ce2_n   (ce2_n),
      .adsp_n  (adsp_n),
      .adsc_n  (adsc_n),
      .gw_n    (gw_n),
      .bwe_n   (bwe_n),
      .bw_n    (bw_n),
      .zz      (zz),
      .act_q   (act_q),
      .cyc     (cyc),
      .lane_we (lane_we)
   );

   assign start = (cyc == CYC_CTRL_START) || (cyc == CYC_PROC_START);
   assign step  = (cyc == CYC_CONT) && !adv_n;

   fsb_burst #(.ADDR_W(ADDR_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .step     (step),
      .mode_in  (mode),
      .addr_in  (addr),
      .addr_nxt (addr_nxt),
      .addr_q   (addr_q)
   );

   fsb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk   (clk),
      .we    (lane_we),
      .waddr (addr_nxt),
      .wdata (din),
      .raddr (addr_q),
      .rdata (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         rd_q  <= 1'b0;
      end else begin
         act_q <= (cyc != CYC_IDLE);
         rd_q  <= (cyc != CYC_IDLE) && (lane_we == '0);
      end
   end

   assign q_drive = ~oe_n & rd_q;
   assign q_data  = q_drive ? rdata : '0;

endmodule

// File: rtl/fsb_sram_sva.sv
module fsb_sram_sva #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              ce2,
   input logic              ce2_n,
   input logic              adsp_n,
   input logic              adsc_n,
   input logic              adv_n,
   input logic              gw_n,
   input logic              zz,
   input logic              oe_n,
   input logic              q_drive,
   input logic              act_q,
   input logic [LANES-1:0]  lane_we,
   input logic [ADDR_W-1:0] addr_q
);
   logic sel_in, cont_in;
   assign sel_in  = !ce_n && ce2 && !ce2_n;
   assign cont_in = act_q && !zz && adsc_n && (adsp_n || ce_n);

   AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!adsc_n && !sel_in) |-> (lane_we == '0)); // R1

   AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!zz && !adsc_n && !sel_in) |=> !q_drive); // R1

   AST_CTRL_GLOBAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!zz && !adsc_n && sel_in && !gw_n) |-> (&lane_we)); // R9

   AST_PROC_START_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!zz && adsc_n && !adsp_n && !ce_n) |-> (lane_we == '0)); // R3

   AST_ADSP_IGNORED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cont_in && ce_n && !adsp_n && !adv_n) |=> (addr_q[1:0] != $past(addr_q[1:0]))); // R4

   AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (cont_in && adv_n) |=> $stable(addr_q)); // R5

   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      cont_in |=> (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]))); // R7

   AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !q_drive); // R10

   AST_ZZ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      zz |-> (lane_we == '0)); // R11

   AST_ZZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      zz |=> (!act_q && !q_drive)); // R11

endmodule

bind fsb_sram fsb_sram_sva #(.ADDR_W(ADDR_W), .LANES(LANES)) u_sva (
   .clk     (clk),
   .rst_n   (rst_n),
   .ce_n    (ce_n),
   .ce2     (ce2),
   .ce2_n   (ce2_n),
   .adsp_n  (adsp_n),
   .adsc_n  (adsc_n),
   .adv_n   (adv_n),
   .gw_n    (gw_n),
   .zz      (zz),
   .oe_n    (oe_n),
   .q_drive (q_drive),
   .act_q   (act_q),
   .lane_we (lane_we),
   .addr_q  (addr_q)
);

// File: tb/tb_fsb_sram.sv
`timescale 1ns/1ps
module tb_fsb_sram;
   localparam int AW    = 8;
   localparam int NL    = 4;
   localparam int LW    = 8;
   localparam int DW    = NL * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic ce_n = 1'b0, ce2 = 1'b1, ce2_n = 1'b0;
   logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
   logic gw_n = 1'b1, bwe_n = 1'b1;
   logic [NL-1:0] bw_n = '1;
   logic mode = 1'b0, zz = 1'b0, oe_n = 1'b0;
   logic [DW-1:0] q_data;
   logic          q_drive;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   fsb_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
      .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n),
      .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
      .mode(mode), .zz(zz), .oe_n(oe_n),
      .q_data(q_data), .q_drive(q_drive)
   );

   // Behavioural reference, updated on each rising edge from the sampled inputs.
   logic [DW-1:0] ref_mem [DEPTH];
   bit m_act = 0, m_rd = 0, m_md = 0;
   int m_up = 0, m_st = 0, m_cnt = 0, m_addr = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0;
         m_rd  = 0;
      end else begin
         bit sel;
         int kind;
         logic [NL-1:0] mask;
         sel  = !ce_n && ce2 && !ce2_n;
         mask = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
         if (zz)                      kind = 0;
         else if (!adsc_n)            kind = sel ? 1 : 0;
         else if (!adsp_n && !ce_n)   kind = sel ? 2 : 0;
         else                         kind = m_act ? 3 : 0;
         if (kind == 0 || kind == 2) mask = '0;
         if (kind == 1 || kind == 2) begin
            m_up  = int'(addr) / 4;
            m_st  = int'(addr) % 4;
            m_cnt = 0;
            m_md  = mode;
         end else if (kind == 3 && !adv_n) begin
            m_cnt = (m_cnt + 1) % 4;
         end
         m_act  = (kind != 0);
         m_addr = m_up * 4 + (m_md ? (m_st ^ m_cnt) : ((m_st + m_cnt) % 4));
         for (int i = 0; i < NL; i++)
            if (mask[i]) ref_mem[m_addr][i*LW +: LW] = din[i*LW +: LW];
         m_rd = m_act && (mask == '0);
      end
   end

   task automatic check(input string tag);
      logic          e_drv;
      logic [DW-1:0] e_dat;
      e_drv = !oe_n && m_rd;
      e_dat = e_drv ? ref_mem[m_addr] : '0;
      checks++;
      if (q_drive !== e_drv || q_data !== e_dat) begin
         fails++;
         $display("FAIL %s t=%0t drive=%b data=%h expected drive=%b data=%h",
                  tag, $time, q_drive, q_data, e_drv, e_dat);
      end
   endtask

   task automatic tick(input string tag);
      @(negedge clk);
      check(tag);
   endtask

   task automatic quiet();
      ce_n = 1'b0; ce2 = 1'b1; ce2_n = 1'b0;
      adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; zz = 1'b0;
   endtask

   // Controller-strobe read burst of four words from a, order md.
   task automatic read_burst(input int a, input logic md, input string tag);
      quiet();
      addr = AW'(a); mode = md; adsc_n = 1'b0;
      tick(tag);
      quiet(); adv_n = 1'b0;
      repeat (3) tick(tag);
      quiet();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick("R12");
      tick("R12");

      // Fill every word with global-write linear bursts.
      for (int b = 0; b < DEPTH; b += 4) begin
         quiet(); mode = 1'b0; addr = AW'(b); adsc_n = 1'b0; gw_n = 1'b0;
         din = 32'hA500_0000 ^ DW'(b * 32'h0101_0103);
         tick("R9");
         for (int k = 1; k < 4; k++) begin
            quiet(); adv_n = 1'b0; gw_n = 1'b0;
            din = 32'h5A00_0000 ^ DW'((b + k) * 32'h0103_0107);
            tick("R9");
         end
      end
      quiet();

      // Linear burst from offset 2, then hold without advance.
      read_burst(8'h12, 1'b0, "R7");
      repeat (2) tick("R5");

      // Interleaved burst started by the processor strobe, offset 1.
      quiet(); addr = 8'h31; mode = 1'b1; adsp_n = 1'b0;
      tick("R6");
      quiet(); adv_n = 1'b0;
      repeat (3) tick("R6");
      read_burst(8'h47, 1'b1, "R6");

      // Processor start with write controls asserted must not write.
      quiet(); addr = 8'h50; adsp_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b0; bw_n = '0;
      din = 32'hDEAD_BEEF;
      tick("R3");
      read_burst(8'h50, 1'b0, "R3");

      // Byte-masked write, then byte enables without qualifier.
      quiet(); addr = 8'h60; adsc_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b1010;
      din = 32'h1122_3344;
      tick("R8");
      quiet(); adv_n = 1'b0; bwe_n = 1'b1; bw_n = 4'b0000; din = 32'hFFFF_FFFF;
      tick("R8");
      read_burst(8'h60, 1'b0, "R8");

      // Global write overrides lane enables.
      quiet(); addr = 8'h64; adsc_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b1; bw_n = '1;
      din = 32'hCAFE_F00D;
      tick("R9");
      read_burst(8'h64, 1'b0, "R9");

      // Both strobes low: controller strobe wins and writes.
      quiet(); addr = 8'h6B; adsc_n = 1'b0; adsp_n = 1'b0; gw_n = 1'b0;
      din = 32'h0BAD_CAFE;
      tick("R2");
      read_burst(8'h68, 1'b1, "R2");

      // Deselect through each enable in turn, with write attempts.
      for (int e = 0; e < 3; e++) begin
         quiet(); addr = 8'h70; adsc_n = 1'b0; gw_n = 1'b0; din = 32'h7777_0000 + e;
         if (e == 0) ce_n = 1'b1;
         if (e == 1) ce2 = 1'b0;
         if (e == 2) ce2_n = 1'b1;
         tick("R1");
         quiet(); adv_n = 1'b0;
         tick("R1");
      end
      read_burst(8'h70, 1'b0, "R1");

      // Processor strobe with primary enable high during a burst is ignored.
      quiet(); addr = 8'h80; mode = 1'b0; adsc_n = 1'b0;
      tick("R4");
      quiet(); ce_n = 1'b1; adsp_n = 1'b0; adv_n = 1'b0; addr = 8'h9C;
      repeat (3) tick("R4");
      quiet();

      // Snooze during a burst, with write attempts, then exit.
      quiet(); addr = 8'h90; adsc_n = 1'b0;
      tick("R11");
      quiet(); zz = 1'b1; gw_n = 1'b0; adv_n = 1'b0; din = 32'h2222_2222;
      repeat (3) tick("R11");
      quiet(); adv_n = 1'b0;
      repeat (2) tick("R11");
      read_burst(8'h90, 1'b0, "R11");

      // Output enable high during a read burst.
      quiet(); oe_n = 1'b1;
      read_burst(8'hA0, 1'b1, "R10");
      oe_n = 1'b0;
      tick("R10");

      // Random traffic over all controls.
      for (int i = 0; i < 3000; i++) begin
         addr   = AW'($urandom);
         din    = DW'($urandom);
         ce_n   = ($urandom % 8) == 0;
         ce2    = ($urandom % 8) != 0;
         ce2_n  = ($urandom % 8) == 0;
         adsc_n = ($urandom % 4) != 0;
         adsp_n = ($urandom % 4) != 0;
         adv_n  = ($urandom % 3) == 0;
         gw_n   = ($urandom % 5) != 0;
         bwe_n  = ($urandom % 3) != 0;
         bw_n   = NL'($urandom);
         mode   = 1'($urandom);
         zz     = ($urandom % 20) == 0;
         oe_n   = ($urandom % 6) == 0;
         tick("R10");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R12 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule